// File: doc/BRIEF.md
# Programmable Logic Macrocell

One logic cell of a sum-of-products programmable device. A set of array inputs is matched against programmable product terms, where each input can be taken as it is, inverted, or left out. Eight product terms form a sum. The sum can be inverted, and it is then either sent straight to the pin or stored in a flip-flop that works as D or T type. A further three product terms build a local clock, an asynchronous clear and a pin enable for the cell. The pin is tri-state. A feedback output returns either the stored bit or whatever value is present on the pin to the routing that lies outside the cell.

All configuration arrives as static input vectors and mode bits. These are expected to change only while the global reset is held, which is how a programmed part behaves once it is loaded. The global reset is active low and also clears the stored bit. The flip-flop is clocked by the global clock or by the local clock term, and a configuration bit picks the rising or the falling edge of the chosen clock.

Top module: `pldMacrocell`

## Requirements
- R1: Each product term holds a 2-bit code per array input, with input i at bits [2i+1:2i]: 00 leaves the input out, 01 needs it high, 10 needs it low, and 11 forces the term to 0. A term whose codes are all 00 is 1.
- R2: The sum is the OR of NUM_PT product terms, where term t is configured by sumCfg[t*2*NUM_IN +: 2*NUM_IN].
- R3: When cfgInvert is 1 the sum is complemented before it reaches the output select and the flip-flop.
- R4: When cfgRegOut is 0 the pin carries the combinational polarity-adjusted sum. When it is 1 the pin carries the stored bit.
- R5: With cfgToggle at 0 the flip-flop loads the polarity-adjusted sum on each active clock edge.
- R6: With cfgToggle at 1 the flip-flop inverts its stored bit on an active edge when the polarity-adjusted sum is 1, and holds it otherwise.
- R7: cfgFallEdge at 0 makes the rising edge of the selected clock active. At 1 the falling edge is active.
- R8: cfgLocalClk at 0 selects gclk. At 1 the flip-flop is clocked by the clock product term (clkTermCfg) in place of gclk.
- R9: While the clear product term (clrTermCfg) is 1, the stored bit is 0 at once, and it overrides any clock edge.
- R10: While rstN is 0 the stored bit is 0.
- R11: In global-clock mode the pin is driven only while the enable product term (oeTermCfg) is 1, and it is high-impedance otherwise. In local-clock mode the pin is always driven.
- R12: fbOut is the value on the pin when cfgFbPin is 1, including a value driven from outside while the cell's driver is off. When cfgFbPin is 0, fbOut is the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| rstN | input | 1 | Global asynchronous reset, active low |
| arrayIn | input | NUM_IN | Array input signals |
| sumCfg | input | NUM_PT*2*NUM_IN | Literal codes of the sum product terms |
| clkTermCfg | input | 2*NUM_IN | Literal codes of the local clock term |
| clrTermCfg | input | 2*NUM_IN | Literal codes of the clear term |
| oeTermCfg | input | 2*NUM_IN | Literal codes of the pin enable term |
| cfgInvert | input | 1 | Complement the sum |
| cfgRegOut | input | 1 | Send the stored bit to the pin instead of the sum |
| cfgToggle | input | 1 | T-type flip-flop instead of D-type |
| cfgFallEdge | input | 1 | Falling edge active |
| cfgLocalClk | input | 1 | Clock from the clock term instead of gclk |
| cfgFbPin | input | 1 | Feed back the pin value instead of the stored bit |
| padIo | inout | 1 | Tri-state pin |
| fbOut | output | 1 | Feedback toward the array |

## Verification
The assertions assume that the configuration stays constant while rstN is high. They also assume that the array inputs change only between global clock edges, so the clear term they sample at one edge still holds at the next. The bench follows both rules. It changes configuration only with rstN low, and it moves the data inputs once per cycle, well clear of either gclk edge. In local-clock mode it drives the clock-term input apart from the data inputs, and no other term uses that input, so no local edge ever coincides with a data change.

// File: rtl/pldMcPkg.sv
package pldMcPkg;

  // Static personality bits of the cell
  typedef struct packed {
    logic invertSum;
    logic selReg;
    logic toggleFf;
    logic fallEdge;
    logic localClk;
    logic fbPin;
  } mcMode_t;

  // Strobes the control half hands to the datapath
  typedef struct packed {
    logic regClk;
    logic regClr;
    logic outEn;
    logic toggle;
    logic selReg;
    logic fbPin;
    logic invert;
  } mcStrobe_t;

endpackage

// File: rtl/mcProductTerm.sv
module mcProductTerm #(
  parameter int NUM_IN = 8
) (
  input  logic [NUM_IN-1:0]   arrayIn,
  input  logic [2*NUM_IN-1:0] termCfg,
  output logic                termOut
);

  logic [NUM_IN-1:0] litOk;

  // Code bit 0 asks for the true form, code bit 1 asks for the complement
  for (genvar i = 0; i < NUM_IN; i++) begin : gLit
    assign litOk[i] = (~termCfg[2*i] | arrayIn[i]) & (~termCfg[2*i+1] | ~arrayIn[i]);
  end

  assign termOut = &litOk;

endmodule

// File: rtl/mcTermArray.sv
module mcTermArray #(
  parameter int NUM_IN = 8,
  parameter int NUM_PT = 8
) (
  input  logic [NUM_IN-1:0]          arrayIn,
  input  logic [NUM_PT*2*NUM_IN-1:0] sumCfg,
  input  logic [2*NUM_IN-1:0]        clkTermCfg,
  input  logic [2*NUM_IN-1:0]        clrTermCfg,
  input  logic [2*NUM_IN-1:0]        oeTermCfg,
  output logic [NUM_PT-1:0]          sumTerms,
  output logic                       clkTerm,
  output logic                       clrTerm,
  output logic                       oeTerm
);

  localparam int TERM_W = 2 * NUM_IN;

  for (genvar t = 0; t < NUM_PT; t++) begin : gSum
    mcProductTerm #(.NUM_IN(NUM_IN)) uTerm (
      .arrayIn (arrayIn),
      .termCfg (sumCfg[t*TERM_W +: TERM_W]),
      .termOut (sumTerms[t])
    );
  end

  mcProductTerm #(.NUM_IN(NUM_IN)) uClkTerm (
    .arrayIn (arrayIn),
    .termCfg (clkTermCfg),
    .termOut (clkTerm)
  );

  mcProductTerm #(.NUM_IN(NUM_IN)) uClrTerm (
    .arrayIn (arrayIn),
    .termCfg (clrTermCfg),
    .termOut (clrTerm)
  );

  mcProductTerm #(.NUM_IN(NUM_IN)) uOeTerm (
    .arrayIn (arrayIn),
    .termCfg (oeTermCfg),
    .termOut (oeTerm)
  );

endmodule

// File: rtl/mcControl.sv
module mcControl
  import pldMcPkg::*;
(
  input  logic      gclk,
  input  logic      rstN,
  input  logic      clkTerm,
  input  logic      clrTerm,
  input  logic      oeTerm,
  input  mcMode_t   mode,
  output mcStrobe_t stb
);

  logic srcClk;

  // Clock source, then edge polarity
  assign srcClk     = mode.localClk ? clkTerm : gclk;
  assign stb.regClk = srcClk ^ mode.fallEdge;

  // Clear: product term or global reset
  assign stb.regClr = clrTerm | ~rstN;

  // The enable term is free only when the clock term is not in use
  assign stb.outEn  = mode.localClk | oeTerm;

  assign stb.toggle = mode.toggleFf;
  assign stb.selReg = mode.selReg;
  assign stb.fbPin  = mode.fbPin;
  assign stb.invert = mode.invertSum;

endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import pldMcPkg::*;
#(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] sumTerms,
  input  mcStrobe_t         stb,
  input  logic              padIn,
  output logic              sumPol,
  output logic              outVal,
  output logic              outEn,
  output logic              fbOut
);

  logic regQ;
  logic nextQ;
  logic clkNet;
  logic clrNet;

  assign clkNet = stb.regClk;
  assign clrNet = stb.regClr;

  assign sumPol = (|sumTerms) ^ stb.invert;
  assign nextQ  = stb.toggle ? (regQ ^ sumPol) : sumPol;

  always_ff @(posedge clkNet or posedge clrNet) begin
    if (clrNet) regQ <= 1'b0;
    else        regQ <= nextQ;
  end

  assign outVal = stb.selReg ? regQ : sumPol;
  assign outEn  = stb.outEn;
  assign fbOut  = stb.fbPin ? padIn : regQ;

endmodule

// File: rtl/pldMacrocell.sv
module pldMacrocell
  import pldMcPkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_PT = 8
) (
  input  logic                       gclk,
  input  logic                       rstN,
  input  logic [NUM_IN-1:0]          arrayIn,
  input  logic [NUM_PT*2*NUM_IN-1:0] sumCfg,
  input  logic [2*NUM_IN-1:0]        clkTermCfg,
  input  logic [2*NUM_IN-1:0]        clrTermCfg,
  input  logic [2*NUM_IN-1:0]        oeTermCfg,
  input  logic                       cfgInvert,
  input  logic                       cfgRegOut,
  input  logic                       cfgToggle,
  input  logic                       cfgFallEdge,
  input  logic                       cfgLocalClk,
  input  logic                       cfgFbPin,
  inout  wire                        padIo,
  output logic                       fbOut
);

  logic [NUM_PT-1:0] sumTerms;
  logic clkTerm;
  logic clrTerm;
  logic oeTerm;
  logic sumPol;
  logic outVal;
  logic outEn;
  logic padIn;
  mcMode_t   mode;
  mcStrobe_t stb;

  assign mode.invertSum = cfgInvert;
  assign mode.selReg    = cfgRegOut;
  assign mode.toggleFf  = cfgToggle;
  assign mode.fallEdge  = cfgFallEdge;
  assign mode.localClk  = cfgLocalClk;
  assign mode.fbPin     = cfgFbPin;

  mcTermArray #(.NUM_IN(NUM_IN), .NUM_PT(NUM_PT)) uArray (
    .arrayIn    (arrayIn),
    .sumCfg     (sumCfg),
    .clkTermCfg (clkTermCfg),
    .clrTermCfg (clrTermCfg),
    .oeTermCfg  (oeTermCfg),
    .sumTerms   (sumTerms),
    .clkTerm    (clkTerm),
    .clrTerm    (clrTerm),
    .oeTerm     (oeTerm)
  );

  mcControl uCtrl (
    .gclk    (gclk),
    .rstN    (rstN),
    .clkTerm (clkTerm),
    .clrTerm (clrTerm),
    .oeTerm  (oeTerm),
    .mode    (mode),
    .stb     (stb)
  );

  mcDatapath #(.NUM_PT(NUM_PT)) uPath (
    .sumTerms (sumTerms),
    .stb      (stb),
    .padIn    (padIn),
    .sumPol   (sumPol),
    .outVal   (outVal),
    .outEn    (outEn),
    .fbOut    (fbOut)
  );

  assign padIo = outEn ? outVal : 1'bz;
  assign padIn = padIo;

endmodule

// File: rtl/mcMacrocellChk.sv
module mcMacrocellChk (
  input logic gclk,
  input logic rstN,
  input logic cfgRegOut,
  input logic cfgToggle,
  input logic cfgFallEdge,
  input logic cfgLocalClk,
  input logic cfgFbPin,
  input logic padIo,
  input logic fbOut,
  input logic sumPol,
  input logic clrTerm
);

  // R9
  clear_forces_zero_chk: assert property (@(posedge gclk) disable iff (!rstN)
    (clrTerm && !cfgFbPin) |-> (fbOut == 1'b0));

  // R11
  local_clk_pin_driven_chk: assert property (@(posedge gclk) disable iff (!rstN)
    cfgLocalClk |-> !$isunknown(padIo));

  // R4
  comb_out_follows_sum_chk: assert property (@(posedge gclk) disable iff (!rstN)
    (cfgLocalClk && !cfgRegOut) |-> (padIo == sumPol));

  // R5
  d_load_chk: assert property (@(posedge gclk) disable iff (!rstN)
    (!cfgLocalClk && !cfgFallEdge && !cfgToggle && !cfgFbPin && !clrTerm)
      |=> (clrTerm || fbOut == $past(sumPol)));

  // R6
  t_toggle_chk: assert property (@(posedge gclk) disable iff (!rstN)
    (!cfgLocalClk && !cfgFallEdge && cfgToggle && !cfgFbPin && !clrTerm)
      |=> (clrTerm || fbOut == ($past(fbOut) ^ $past(sumPol))));

endmodule

bind pldMacrocell mcMacrocellChk uChk (
  .gclk        (gclk),
  .rstN        (rstN),
  .cfgRegOut   (cfgRegOut),
  .cfgToggle   (cfgToggle),
  .cfgFallEdge (cfgFallEdge),
  .cfgLocalClk (cfgLocalClk),
  .cfgFbPin    (cfgFbPin),
  .padIo       (padIo),
  .fbOut       (fbOut),
  .sumPol      (sumPol),
  .clrTerm     (clrTerm)
);

// File: tb/tb_pldMacrocell.sv
module tb_pldMacrocell;

  localparam int NI = 8;
  localparam int NP = 8;
  localparam int TW = 2 * NI;

  logic gclk = 1'b0;
  always #4 gclk = ~gclk;   // 125 MHz

  logic            rstN = 1'b0;
  logic [NI-1:0]   arrayIn = '0;
  logic [NP*TW-1:0] sumCfg = '0;
  logic [TW-1:0]   clkCfg = '0;
  logic [TW-1:0]   clrCfg = '0;
  logic [TW-1:0]   oeCfg = '0;
  logic cfgInvert = 1'b0, cfgRegOut = 1'b0, cfgToggle = 1'b0;
  logic cfgFallEdge = 1'b0, cfgLocalClk = 1'b0, cfgFbPin = 1'b0;
  logic extEn = 1'b0, extVal = 1'b0;
  wire  padIo;
  logic fbOut;
  int   nRun = 0;
  int   nFail = 0;
  logic qModel = 1'b0;

  assign padIo = extEn ? extVal : 1'bz;

  pldMacrocell #(.NUM_IN(NI), .NUM_PT(NP)) dut (
    .gclk        (gclk),
    .rstN        (rstN),
    .arrayIn     (arrayIn),
    .sumCfg      (sumCfg),
    .clkTermCfg  (clkCfg),
    .clrTermCfg  (clrCfg),
    .oeTermCfg   (oeCfg),
    .cfgInvert   (cfgInvert),
    .cfgRegOut   (cfgRegOut),
    .cfgToggle   (cfgToggle),
    .cfgFallEdge (cfgFallEdge),
    .cfgLocalClk (cfgLocalClk),
    .cfgFbPin    (cfgFbPin),
    .padIo       (padIo),
    .fbOut       (fbOut)
  );

  // ---------------- reference functions (R1, R2, R3, R11) ----------------
  function automatic logic termVal(logic [TW-1:0] c, logic [NI-1:0] x);
    logic r = 1'b1;
    for (int i = 0; i < NI; i++) begin
      if (c[2*i]   && !x[i]) r = 1'b0;
      if (c[2*i+1] &&  x[i]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic sumVal(logic [NI-1:0] x);
    logic s = 1'b0;
    for (int t = 0; t < NP; t++) s = s | termVal(sumCfg[t*TW +: TW], x);
    return s ^ cfgInvert;
  endfunction

  function automatic logic oeVal(logic [NI-1:0] x);
    return cfgLocalClk ? 1'b1 : termVal(oeCfg, x);
  endfunction

  function automatic logic nextQ(logic [NI-1:0] x);
    return cfgToggle ? (qModel ^ sumVal(x)) : sumVal(x);
  endfunction

  function automatic logic [TW-1:0] genTerm(int density);
    logic [TW-1:0] c = '0;
    for (int i = 0; i < NI - 1; i++)
      if (($urandom % 8) < density) c[2*i +: 2] = 2'($urandom % 3 + 1);
    return c;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setPad();
    extEn  = !oeVal(arrayIn);
    extVal = 1'($urandom % 2);
  endtask

  task automatic checkOutputs(string tag);
    logic padExp;
    logic fbExp;
    padExp = oeVal(arrayIn) ? (cfgRegOut ? qModel : sumVal(arrayIn)) : extVal;
    fbExp  = cfgFbPin ? padExp : qModel;
    check({tag, " pad"}, padIo, padExp);
    check({tag, " fb"}, fbOut, fbExp);
  endtask

  task automatic enterReset();
    @(posedge gclk); #1;
    rstN   = 1'b0;
    qModel = 1'b0;
  endtask

  // Called with the new configuration already in place, rstN still low
  task automatic leaveReset();
    setPad();
    #1;
    checkOutputs("R10 reset");
    @(posedge gclk); #1;
    rstN = 1'b1;
  endtask

  // One cycle: data at +1, clock-term input at +2, sample at +3
  task automatic runCycle(string tag, logic [NI-2:0] data, logic b7);
    logic [NI-1:0] prev;
    logic oldClk;
    logic newClk;
    @(posedge gclk); #1;
    prev = arrayIn;
    if (!cfgLocalClk && !termVal(clrCfg, prev)) qModel = nextQ(prev);
    arrayIn[NI-2:0] = data;
    if (termVal(clrCfg, arrayIn)) qModel = 1'b0;
    setPad();
    #1;
    if (cfgLocalClk) begin
      oldClk = termVal(clkCfg, arrayIn) ^ cfgFallEdge;
      arrayIn[NI-1] = b7;
      newClk = termVal(clkCfg, arrayIn) ^ cfgFallEdge;
      if (!oldClk && newClk && !termVal(clrCfg, arrayIn)) qModel = nextQ(arrayIn);
    end else begin
      arrayIn[NI-1] = b7;
    end
    #1;
    checkOutputs(tag);
  endtask

  task automatic killAllSum();
    for (int t = 0; t < NP; t++) sumCfg[t*TW +: TW] = {{(TW-2){1'b0}}, 2'b11};
  endtask

  task automatic plainMode();
    cfgInvert = 1'b0; cfgRegOut = 1'b0; cfgToggle = 1'b0;
    cfgFallEdge = 1'b0; cfgLocalClk = 1'b0; cfgFbPin = 1'b0;
    clkCfg = '0;
    clrCfg = {{(TW-2){1'b0}}, 2'b11};   // clear term forced off
    oeCfg  = '0;                        // enable term always on
  endtask

  initial begin
    void'($urandom(32'd20250611));
    // Reset state (R10)
    #3;
    setPad();
    #1;
    check("R10 initial fb", fbOut, 1'b0);

    // R1 R2 R4: one all-ignore term makes the sum 1, the rest are forced off
    enterReset();
    plainMode();
    killAllSum();
    sumCfg[3*TW +: TW] = '0;
    leaveReset();
    for (int k = 0; k < 4; k++) runCycle("R1 R2 R4 all-ignore term", (NI-1)'($urandom), 1'b0);

    // R1 R3: a term needing both forms of an input is 0, inverted sum gives 1
    enterReset();
    plainMode();
    killAllSum();
    sumCfg[0 +: TW] = '0;
    sumCfg[2*2 +: 2] = 2'b11;
    cfgInvert = 1'b1;
    leaveReset();
    for (int k = 0; k < 4; k++) runCycle("R1 R3 contradictory literal", (NI-1)'($urandom), 1'b0);

    // R8 R9: local clock on input 7, clear term on input 0 overrides edges
    enterReset();
    plainMode();
    killAllSum();
    sumCfg[0 +: TW] = '0;
    cfgLocalClk = 1'b1;
    cfgRegOut   = 1'b1;
    clkCfg = '0; clkCfg[2*(NI-1)] = 1'b1;
    clrCfg = '0; clrCfg[0] = 1'b1;
    arrayIn = '0;
    leaveReset();
    for (int k = 0; k < 4; k++) runCycle("R9 clear beats local edge", 7'b0000001, 1'(k % 2));
    runCycle("R8 R9 clear released", 7'b0000000, 1'b0);
    runCycle("R8 local rising edge loads", 7'b0000000, 1'b1);

    // R11 R12: enable term off in global mode, pin value comes back as feedback
    enterReset();
    plainMode();
    oeCfg = {{(TW-2){1'b0}}, 2'b11};
    cfgFbPin = 1'b1;
    for (int t = 0; t < NP; t++) sumCfg[t*TW +: TW] = genTerm(2);
    leaveReset();
    for (int k = 0; k < 6; k++) runCycle("R11 R12 pin released", (NI-1)'($urandom), 1'b0);

    // Random personalities: R2 R3 R4 R5 R6 R7 R8 R9 R11 R12
    for (int c = 0; c < 40; c++) begin
      enterReset();
      for (int t = 0; t < NP; t++) sumCfg[t*TW +: TW] = genTerm(2);
      clrCfg = genTerm(2);
      if ($urandom % 2 == 0) clrCfg[1:0] = 2'b11;
      oeCfg = genTerm(1);
      cfgInvert   = 1'($urandom % 2);
      cfgRegOut   = 1'($urandom % 2);
      cfgToggle   = 1'($urandom % 2);
      cfgFallEdge = 1'($urandom % 2);
      cfgLocalClk = 1'($urandom % 2);
      cfgFbPin    = 1'($urandom % 2);
      clkCfg = '0;
      clkCfg[2*(NI-1)] = 1'b1;
      leaveReset();
      for (int k = 0; k < 50; k++)
        runCycle("R5 R6 R7 R8 R9 R11 R12 random", (NI-1)'($urandom), 1'($urandom % 2));
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule